// File: doc/BRIEF.md
# Hardware Breakpoint Match Unit

This debug block compares each memory event a core produces against four programmable breakpoint addresses. Every event carries a linear address, a byte count and a kind (instruction fetch, data write or data read). A breakpoint counts as live when its local or its global enable is set. A live breakpoint hits when two things are true: its two-bit condition accepts the event kind, and the event's byte span overlaps the breakpoint's naturally aligned window. When at least one breakpoint hits, or a single-step request arrives, the block raises a one-cycle debug exception. In the same cycle, sticky status bits show which breakpoints hit and whether a step caused the exception.

Software reaches the four address registers, the control word and the status word through one indexed register port. Writes are synchronous and reads are combinational. A task-switch pulse drops every local enable and leaves the global enables as they were. This lets a debugger keep some breakpoints tied to one task and others tied to the whole system.

Top module: `bkpt_match_unit`

## Requirements
- R1: After reset every register reads zero at all eight indices, no breakpoint is live and dbg_exc_o is low.
- R2: Register index 0..3 selects breakpoint address n, 4 the control word, 5 the status word; indices 6 and 7 read zero and ignore writes. Control bits 8..15 read zero; of the status word only bits 0..3 and 14 are stored. Reads are combinational on reg_sel_i.
- R3: Breakpoint n is live when control bit 2n (local) or bit 2n+1 (global) is set; a breakpoint with neither bit set never hits.
- R4: Condition code for breakpoint n sits in control bits 16+4n..17+4n. Code 00 accepts fetches (acc_kind_i 00) only, 01 accepts writes (01) only, 11 accepts writes or reads (10), and 10 never hits. Kind 11 hits nothing.
- R5: Size code for breakpoint n sits in control bits 18+4n..19+4n, and acc_size_i uses the same code: 00 = 1 byte, 01 = 2, 11 = 4, 10 = 8. The breakpoint window starts at its address rounded down to a multiple of its size. A hit requires the access bytes to overlap that window.
- R6: A fetch breakpoint (code 00) hits only when its size code is 00.
- R7: A task_switch_i pulse clears all local enable bits at that clock edge and keeps all global bits. A breakpoint that is enabled only locally cannot hit during the pulse cycle. The clearing applies after a control write in the same cycle.
- R8: dbg_exc_o is high for exactly the cycle after a cycle with a hit or step_i, and low otherwise.
- R9: Status bit n is set together with dbg_exc_o for every breakpoint that hit; several may be set at once.
- R10: step_i sets status bit 14 and raises dbg_exc_o one cycle later.
- R11: Status bits are sticky. A write to index 5 replaces the stored bits, and a hit or step in the same cycle still sets its bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 3 | Register index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for reg_sel_i |
| acc_valid_i | input | 1 | Memory event valid |
| acc_addr_i | input | ADDR_W | Event linear address |
| acc_size_i | input | 2 | Event byte-count code |
| acc_kind_i | input | 2 | Event kind: 00 fetch, 01 write, 10 read |
| task_switch_i | input | 1 | Hardware task-switch pulse |
| step_i | input | 1 | Single-step trap request |
| dbg_exc_o | output | 1 | Debug exception pulse |

## Verification
Some properties are checked on every cycle: the reserved condition never hits, fetch breakpoints hit only at byte size, and a hit needs a live enable. Others are the effect of a task switch on the enables, the one-cycle link from a hit or step to the exception, and the stickiness of status bits between software writes. The bench scenarios cover what only a reference model can judge. These are the window alignment and overlap arithmetic for each size, the exact readback masking of the control and status words, and several breakpoints hitting at once. They also include a status write that lands in the same cycle as a hit.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;
  localparam int NUM_BP   = 4;
  localparam int REG_W    = 32;
  localparam int SEL_W    = 3;
  localparam int STEP_BIT = 14;
  localparam int COND_LSB = 16;
  localparam int FIELD_W  = 4;

  localparam logic [SEL_W-1:0] SEL_CTRL = 3'd4;
  localparam logic [SEL_W-1:0] SEL_STAT = 3'd5;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_READ  = 2'b10,
    ACC_NONE  = 2'b11
  } acc_kind_e;

  typedef enum logic [1:0] {
    COND_EXEC = 2'b00,
    COND_WR   = 2'b01,
    COND_RSVD = 2'b10,
    COND_RW   = 2'b11
  } cond_e;

  function automatic logic [3:0] len_bytes(logic [1:0] code);
    case (code)
      2'b00:   return 4'd1;
      2'b01:   return 4'd2;
      2'b11:   return 4'd4;
      default: return 4'd8;
    endcase
  endfunction

  function automatic logic [REG_W-1:0] local_mask();
    logic [REG_W-1:0] m;
    m = '0;
    for (int n = 0; n < NUM_BP; n++) m[2*n] = 1'b1;
    return m;
  endfunction

  function automatic logic [REG_W-1:0] ctrl_wmask();
    logic [REG_W-1:0] m;
    m = '0;
    for (int n = 0; n < NUM_BP; n++) begin
      m[2*n]   = 1'b1;
      m[2*n+1] = 1'b1;
      m[COND_LSB + FIELD_W*n +: FIELD_W] = '1;
    end
    return m;
  endfunction
endpackage

// File: rtl/bkpt_cmp.sv
module bkpt_cmp
  import bkpt_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] bp_addr_i,
  input  logic              loc_en_i,
  input  logic              glb_en_i,
  input  logic [1:0]        cond_i,
  input  logic [1:0]        len_i,
  input  logic              task_switch_i,
  input  logic              acc_valid_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic [1:0]        acc_size_i,
  input  logic [1:0]        acc_kind_i,
  output logic              hit_o
);
  localparam int XW = ADDR_W + 1;

  logic [ADDR_W-1:0] align_mask;
  logic [XW-1:0]     bp_lo, bp_hi, ac_lo, ac_hi;
  logic              armed, cond_ok, overlap;
  acc_kind_e         kind;

  assign kind = acc_kind_e'(acc_kind_i);

  // local enable is masked in the pulse cycle itself
  assign armed = (loc_en_i & ~task_switch_i) | glb_en_i;

  always_comb begin
    align_mask = ~(ADDR_W'(len_bytes(len_i)) - ADDR_W'(1));
    bp_lo      = {1'b0, bp_addr_i & align_mask};
    bp_hi      = bp_lo + XW'(len_bytes(len_i)) - XW'(1);
    ac_lo      = {1'b0, acc_addr_i};
    ac_hi      = ac_lo + XW'(len_bytes(acc_size_i)) - XW'(1);
    overlap    = (ac_lo <= bp_hi) && (bp_lo <= ac_hi);
  end

  always_comb begin
    unique case (cond_e'(cond_i))
      COND_EXEC: cond_ok = (kind == ACC_FETCH) && (len_i == 2'b00);
      COND_WR:   cond_ok = (kind == ACC_WRITE);
      COND_RW:   cond_ok = (kind == ACC_WRITE) || (kind == ACC_READ);
      default:   cond_ok = 1'b0;
    endcase
  end

  assign hit_o = acc_valid_i & armed & cond_ok & overlap;
endmodule

// File: rtl/bkpt_regs.sv
module bkpt_regs
  import bkpt_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           we_i,
  input  logic [SEL_W-1:0]               sel_i,
  input  logic [REG_W-1:0]               wdata_i,
  input  logic                           task_switch_i,
  input  logic [REG_W-1:0]               status_i,
  output logic [NUM_BP-1:0][ADDR_W-1:0]  bp_addr_o,
  output logic [REG_W-1:0]               ctrl_o,
  output logic [REG_W-1:0]               rdata_o
);
  localparam logic [REG_W-1:0] WMASK = ctrl_wmask();
  localparam logic [REG_W-1:0] LMASK = local_mask();

  logic [REG_W-1:0] ctrl_q, ctrl_d;

  for (genvar n = 0; n < NUM_BP; n++) begin : g_addr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              bp_addr_o[n] <= '0;
      else if (we_i && sel_i == SEL_W'(n))      bp_addr_o[n] <= wdata_i[ADDR_W-1:0];
    end
  end

  always_comb begin
    ctrl_d = ctrl_q;
    if (we_i && sel_i == SEL_CTRL) ctrl_d = wdata_i & WMASK;
    if (task_switch_i)             ctrl_d = ctrl_d & ~LMASK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else         ctrl_q <= ctrl_d;
  end

  assign ctrl_o = ctrl_q;

  always_comb begin
    rdata_o = '0;
    if (sel_i < SEL_W'(NUM_BP)) rdata_o = REG_W'(bp_addr_o[sel_i[1:0]]);
    else if (sel_i == SEL_CTRL) rdata_o = ctrl_q;
    else if (sel_i == SEL_STAT) rdata_o = status_i;
  end
endmodule

// File: rtl/bkpt_status.sv
module bkpt_status
  import bkpt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sw_we_i,
  input  logic [NUM_BP:0]   sw_bits_i,
  input  logic [NUM_BP-1:0] hit_i,
  input  logic              step_i,
  output logic              exc_o,
  output logic [REG_W-1:0]  status_o
);
  logic [NUM_BP-1:0] hit_q, hit_base;
  logic              step_q, step_base, exc_q;

  // software write replaces, hardware set wins in the same cycle
  assign hit_base  = sw_we_i ? sw_bits_i[NUM_BP-1:0] : hit_q;
  assign step_base = sw_we_i ? sw_bits_i[NUM_BP]     : step_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_q  <= '0;
      step_q <= 1'b0;
      exc_q  <= 1'b0;
    end else begin
      hit_q  <= hit_base | hit_i;
      step_q <= step_base | step_i;
      exc_q  <= (|hit_i) | step_i;
    end
  end

  always_comb begin
    status_o                 = '0;
    status_o[NUM_BP-1:0]     = hit_q;
    status_o[STEP_BIT]       = step_q;
  end

  assign exc_o = exc_q;
endmodule

// File: rtl/bkpt_match_unit.sv
module bkpt_match_unit
  import bkpt_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_sel_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              acc_valid_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic [1:0]        acc_size_i,
  input  logic [1:0]        acc_kind_i,
  input  logic              task_switch_i,
  input  logic              step_i,
  output logic              dbg_exc_o
);
  logic [NUM_BP-1:0][ADDR_W-1:0] bp_addr;
  logic [REG_W-1:0]              ctrl, status;
  logic [NUM_BP-1:0]             hit_vec;

  bkpt_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .we_i          (reg_we_i),
    .sel_i         (reg_sel_i),
    .wdata_i       (reg_wdata_i),
    .task_switch_i (task_switch_i),
    .status_i      (status),
    .bp_addr_o     (bp_addr),
    .ctrl_o        (ctrl),
    .rdata_o       (reg_rdata_o)
  );

  for (genvar n = 0; n < NUM_BP; n++) begin : g_cmp
    bkpt_cmp #(.ADDR_W(ADDR_W)) u_cmp (
      .bp_addr_i     (bp_addr[n]),
      .loc_en_i      (ctrl[2*n]),
      .glb_en_i      (ctrl[2*n+1]),
      .cond_i        (ctrl[COND_LSB + FIELD_W*n +: 2]),
      .len_i         (ctrl[COND_LSB + FIELD_W*n + 2 +: 2]),
      .task_switch_i (task_switch_i),
      .acc_valid_i   (acc_valid_i),
      .acc_addr_i    (acc_addr_i),
      .acc_size_i    (acc_size_i),
      .acc_kind_i    (acc_kind_i),
      .hit_o         (hit_vec[n])
    );
  end

  bkpt_status u_status (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sw_we_i   (reg_we_i && reg_sel_i == SEL_STAT),
    .sw_bits_i ({reg_wdata_i[STEP_BIT], reg_wdata_i[NUM_BP-1:0]}),
    .hit_i     (hit_vec),
    .step_i    (step_i),
    .exc_o     (dbg_exc_o),
    .status_o  (status)
  );
endmodule

// File: rtl/bkpt_match_chk.sv
module bkpt_match_chk
  import bkpt_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic [2:0]        reg_sel_i,
  input logic              task_switch_i,
  input logic              step_i,
  input logic              dbg_exc_o,
  input logic [REG_W-1:0]  ctrl_i,
  input logic [NUM_BP-1:0] hit_i,
  input logic [REG_W-1:0]  status_i
);
  localparam logic [REG_W-1:0] LMASK = local_mask();
  localparam logic [REG_W-1:0] GMASK = LMASK << 1;

  logic ctrl_wr, stat_wr;
  assign ctrl_wr = reg_we_i && reg_sel_i == SEL_CTRL;
  assign stat_wr = reg_we_i && reg_sel_i == SEL_STAT;

  for (genvar n = 0; n < NUM_BP; n++) begin : g_bp
    AST_LIVE_FOR_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit_i[n] |-> (ctrl_i[2*n] || ctrl_i[2*n+1])); // R3
    AST_RSVD_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit_i[n] |-> ctrl_i[COND_LSB + FIELD_W*n +: 2] != 2'b10); // R4
    AST_EXEC_BYTE_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hit_i[n] && ctrl_i[COND_LSB + FIELD_W*n +: 2] == 2'b00)
        |-> ctrl_i[COND_LSB + FIELD_W*n + 2 +: 2] == 2'b00); // R6
    AST_HIT_RECORDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit_i[n] |=> status_i[n]); // R9
  end

  AST_LOCAL_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    task_switch_i |=> (ctrl_i & LMASK) == '0); // R7
  AST_GLOBAL_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (task_switch_i && !ctrl_wr) |=> (ctrl_i & GMASK) == $past(ctrl_i & GMASK)); // R7
  AST_EXC_HAS_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbg_exc_o |-> $past((|hit_i) || step_i)); // R8
  AST_HIT_RAISES_EXC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|hit_i) || step_i) |=> dbg_exc_o); // R8
  AST_STEP_FLAGGED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> status_i[STEP_BIT]); // R10
  AST_STATUS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stat_wr |=> (status_i & $past(status_i)) == $past(status_i)); // R11
endmodule

bind bkpt_match_unit bkpt_match_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .reg_we_i      (reg_we_i),
  .reg_sel_i     (reg_sel_i),
  .task_switch_i (task_switch_i),
  .step_i        (step_i),
  .dbg_exc_o     (dbg_exc_o),
  .ctrl_i        (ctrl),
  .hit_i         (hit_vec),
  .status_i      (status)
);

// File: tb/sim_bkpt_match_unit.sv
`timescale 1ns/1ps
module sim_bkpt_match_unit;
  localparam real CLK_PERIOD = 8.0;

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        reg_we_i = 1'b0, acc_valid_i = 1'b0, task_switch_i = 1'b0, step_i = 1'b0;
  logic [2:0]  reg_sel_i = '0;
  logic [31:0] reg_wdata_i = '0, acc_addr_i = '0, reg_rdata_o;
  logic [1:0]  acc_size_i = '0, acc_kind_i = '0;
  logic        dbg_exc_o;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [31:0] m_addr [4];
  logic [31:0] m_ctrl, m_stat;

  always #(CLK_PERIOD/2) clk = ~clk;

  bkpt_match_unit u0 (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_sel_i(reg_sel_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .acc_valid_i(acc_valid_i),
    .acc_addr_i(acc_addr_i), .acc_size_i(acc_size_i), .acc_kind_i(acc_kind_i),
    .task_switch_i(task_switch_i), .step_i(step_i), .dbg_exc_o(dbg_exc_o)
  );

  function automatic longint nbytes(logic [1:0] c);
    case (c) 2'b00: return 1; 2'b01: return 2; 2'b11: return 4; default: return 8; endcase
  endfunction

  // R3 R4 R5 R6 R7 reference
  function automatic logic [3:0] model_hits(logic [31:0] a, logic [1:0] sz, logic [1:0] k, logic ts);
    logic [3:0] h = '0;
    for (int n = 0; n < 4; n++) begin
      logic loc = m_ctrl[2*n] && !ts;
      logic glb = m_ctrl[2*n+1];
      logic [1:0] cnd = m_ctrl[16+4*n +: 2];
      logic [1:0] len = m_ctrl[18+4*n +: 2];
      longint lb = nbytes(len);
      longint base = longint'(m_addr[n]) - (longint'(m_addr[n]) % lb);
      longint alo = longint'(a);
      longint ahi = alo + nbytes(sz) - 1;
      logic ov = (alo <= base + lb - 1) && (base <= ahi);
      logic ok;
      case (cnd)
        2'b00: ok = (k == 2'b00) && (len == 2'b00);
        2'b01: ok = (k == 2'b01);
        2'b11: ok = (k == 2'b01) || (k == 2'b10);
        default: ok = 1'b0;
      endcase
      h[n] = (loc || glb) && ok && ov;
    end
    return h;
  endfunction

  function automatic logic [31:0] model_read(logic [2:0] s);
    if (s < 4) return m_addr[s[1:0]];
    if (s == 4) return m_ctrl;
    if (s == 5) return m_stat;
    return '0;
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(logic we, logic [2:0] sel, logic [31:0] wd, logic v, logic [31:0] a,
                     logic [1:0] sz, logic [1:0] k, logic ts, logic st, string tag);
    logic [3:0] h;
    logic exp_exc;
    @(negedge clk);
    reg_we_i = we; reg_sel_i = sel; reg_wdata_i = wd;
    acc_valid_i = v; acc_addr_i = a; acc_size_i = sz; acc_kind_i = k;
    task_switch_i = ts; step_i = st;
    h = v ? model_hits(a, sz, k, ts) : 4'b0;
    exp_exc = (|h) || st;
    if (we && sel < 4) m_addr[sel[1:0]] = wd;
    if (we && sel == 4) m_ctrl = wd & 32'hFFFF_00FF;
    if (ts) m_ctrl = m_ctrl & ~32'h0000_0055;
    if (we && sel == 5) m_stat = wd & 32'h0000_400F;
    m_stat = m_stat | {17'b0, st, 10'b0, h};
    @(posedge clk); #1;
    check(tag, "dbg_exc_o", {31'b0, dbg_exc_o}, {31'b0, exp_exc});
    check(tag, "reg_rdata_o", reg_rdata_o, model_read(sel));
  endtask

  task automatic wr(logic [2:0] sel, logic [31:0] wd, string tag);
    cyc(1'b1, sel, wd, 1'b0, '0, 2'b00, 2'b00, 1'b0, 1'b0, tag);
  endtask

  task automatic acc(logic [31:0] a, logic [1:0] sz, logic [1:0] k, string tag);
    cyc(1'b0, 3'd5, '0, 1'b1, a, sz, k, 1'b0, 1'b0, tag);
  endtask

  task automatic idle(string tag);
    cyc(1'b0, 3'd5, '0, 1'b0, '0, 2'b00, 2'b00, 1'b0, 1'b0, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7741));
    for (int i = 0; i < 4; i++) m_addr[i] = '0;
    m_ctrl = '0; m_stat = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R1", "exc in reset", {31'b0, dbg_exc_o}, 32'h0);
    @(negedge clk); rst_ni = 1'b1;

    // R1 all indices zero
    for (int s = 0; s < 8; s++) cyc(1'b0, 3'(s), '0, 1'b0, '0, 2'b00, 2'b00, 1'b0, 1'b0, "R1");

    // R2 masking and unused indices
    wr(3'd4, 32'hFFFF_FFFF, "R2");
    wr(3'd6, 32'hDEAD_BEEF, "R2");
    cyc(1'b0, 3'd7, '0, 1'b0, '0, 2'b00, 2'b00, 1'b0, 1'b0, "R2");
    wr(3'd5, 32'hFFFF_FFFF, "R2");
    wr(3'd5, 32'h0, "R2");
    wr(3'd2, 32'h1234_5678, "R2");
    wr(3'd4, 32'h0, "R2");

    // R3 no enable: rw cond on bp0 but not live
    wr(3'd0, 32'h100, "R3");
    wr(3'd4, 32'h0003_0000, "R3");
    acc(32'h100, 2'b00, 2'b01, "R3");
    wr(3'd4, 32'h0003_0001, "R3");
    acc(32'h100, 2'b00, 2'b01, "R3");
    idle("R8");
    wr(3'd5, 32'h0, "R11");

    // R4 condition codes
    wr(3'd4, 32'h0002_0002, "R4");
    acc(32'h100, 2'b00, 2'b01, "R4");
    acc(32'h100, 2'b00, 2'b10, "R4");
    wr(3'd4, 32'h0001_0002, "R4");
    acc(32'h100, 2'b00, 2'b10, "R4");
    acc(32'h100, 2'b00, 2'b00, "R4");
    acc(32'h100, 2'b00, 2'b01, "R4");
    wr(3'd4, 32'h0003_0002, "R4");
    acc(32'h100, 2'b00, 2'b10, "R4");
    acc(32'h100, 2'b00, 2'b11, "R4");
    wr(3'd5, 32'h0, "R4");

    // R5 aligned windows, bp1 at 0x203 size 4
    wr(3'd1, 32'h203, "R5");
    wr(3'd4, 32'h00F0_0008, "R5");
    acc(32'h1FF, 2'b01, 2'b10, "R5");
    acc(32'h1FE, 2'b01, 2'b10, "R5");
    acc(32'h204, 2'b00, 2'b01, "R5");
    acc(32'h200, 2'b00, 2'b01, "R5");
    wr(3'd4, 32'h00B0_0008, "R5");
    acc(32'h207, 2'b00, 2'b10, "R5");
    acc(32'h208, 2'b00, 2'b10, "R5");
    acc(32'h1F8, 2'b10, 2'b10, "R5");
    wr(3'd1, 32'hFFFF_FFFF, "R5");
    acc(32'hFFFF_FFFE, 2'b10, 2'b01, "R5");
    wr(3'd5, 32'h0, "R5");

    // R6 fetch needs byte size
    wr(3'd4, 32'h0004_0002, "R6");
    acc(32'h100, 2'b00, 2'b00, "R6");
    wr(3'd4, 32'h0000_0002, "R6");
    acc(32'h100, 2'b00, 2'b00, "R6");
    wr(3'd5, 32'h0, "R6");

    // R7 local vs global on task switch; bp2 local, bp3 global, both fetch at 0x300
    wr(3'd2, 32'h300, "R7");
    wr(3'd3, 32'h300, "R7");
    wr(3'd4, 32'h0000_0090, "R7");
    cyc(1'b0, 3'd5, '0, 1'b1, 32'h300, 2'b00, 2'b00, 1'b1, 1'b0, "R7");
    cyc(1'b0, 3'd4, '0, 1'b0, '0, 2'b00, 2'b00, 1'b0, 1'b0, "R7");
    cyc(1'b1, 3'd4, 32'h0000_00FF, 1'b0, '0, 2'b00, 2'b00, 1'b1, 1'b0, "R7");
    wr(3'd5, 32'h0, "R7");

    // R9 multiple hits together
    wr(3'd4, 32'h0000_00AA, "R9");
    wr(3'd0, 32'h300, "R9");
    wr(3'd1, 32'h300, "R9");
    acc(32'h300, 2'b00, 2'b00, "R9");
    idle("R8");

    // R10 step alone
    cyc(1'b0, 3'd5, '0, 1'b0, '0, 2'b00, 2'b00, 1'b0, 1'b1, "R10");
    idle("R10");

    // R11 clear racing a hit and a step
    cyc(1'b1, 3'd5, 32'h0, 1'b1, 32'h300, 2'b00, 2'b00, 1'b0, 1'b0, "R11");
    cyc(1'b1, 3'd5, 32'h0000_0002, 1'b0, '0, 2'b00, 2'b00, 1'b0, 1'b1, "R11");
    idle("R11");

    // random mix
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom % 16;
      if (r == 0) begin
        logic [2:0] s = 3'($urandom % 8);
        logic [31:0] d = (s < 4) ? ($urandom % 64) : $urandom;
        wr(s, d, "RND");
      end else if (r == 1) begin
        wr(3'd5, 32'h0, "RND");
      end else begin
        cyc(1'b0, 3'd5, '0, ($urandom % 8) != 0, $urandom % 64, 2'($urandom), 2'($urandom),
            ($urandom % 20) == 0, ($urandom % 24) == 0, "RND");
      end
    end
    idle("R8");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule